// File: doc/BRIEF.md
# Fixed-Priority Shared-Bus Interconnect

This block lets several bus masters share one path to a set of memory-mapped slaves using the Wishbone classic signal set. At most one transfer is on the bus at a time. Each cycle the arbiter looks at the masters whose cycle line is high and that are populated. The highest-indexed one wins. Once a master holds the bus it keeps it for as long as its cycle line stays high.

The winning master's 30-bit word address is matched against every populated slave. A slave matches when the top 8 address bits equal the top 8 bits of its base, and when every lower bit that its 22-bit compare mask selects also equals the base. If more than one slave matches, the lowest-indexed match is used. Address, write data, write enable and byte selects go out on shared lines. Strobe and cycle go only to the matched slave. That slave's acknowledge and read data return only to the winning master.

If the winner's address matches nothing, the bus stays quiet and no master gets an answer. The arbiter does not hand the bus to a lower-priority master in that case. Which masters and slaves are populated, and each slave's base and mask, are fixed when the block is elaborated.

Top module: `wb_shared_bus`

## Requirements
- R1: With no grant held, the highest-indexed populated master whose cycle line is high is granted.
- R2: A granted master keeps the grant for as long as its cycle line stays high, even if a higher-indexed master starts requesting. Arbitration runs again in the cycle its cycle line drops.
- R3: A master whose bit in `MST_EN` is 0 is never granted, and it never sees an acknowledge.
- R4: Slave j matches word address A when A[29:22] equals base_j[29:22] and ((A[21:0] XOR base_j[21:0]) AND mask_j) is zero. A mask of zero decodes a whole 4M-word region.
- R5: When several populated slaves match, the lowest-indexed one is selected.
- R6: A slave whose bit in `SLV_EN` is 0 is never selected, even when the address falls in its region.
- R7: When the granted master's address matches no populated slave, every slave strobe and cycle line stays low and every master acknowledge stays low. No lower-priority master is granted in its place.
- R8: While a slave is selected, `s_adr_o`, `s_dat_o`, `s_we_o` and `s_sel_o` carry the granted master's values. Only the selected slave sees cycle high, and it sees strobe high when the master's strobe is high. Otherwise all of these outputs are zero.
- R9: The selected slave's acknowledge and read data appear only on the granted master's slice. Every other master sees acknowledge 0 and read data 0.
- R10: With no populated master requesting, every slave-side output and every master-side output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_cyc_i | input | N_MST | Cycle line for each master (this is the request) |
| m_stb_i | input | N_MST | Strobe for each master |
| m_we_i | input | N_MST | Write enable for each master |
| m_adr_i | input | N_MST*AW | Word address for each master, master i at slice i |
| m_dat_i | input | N_MST*DW | Write data for each master |
| m_sel_i | input | N_MST*SW | Byte selects for each master |
| m_ack_o | output | N_MST | Acknowledge to each master |
| m_dat_o | output | N_MST*DW | Read data to each master |
| s_cyc_o | output | N_SLV | Cycle line to each slave |
| s_stb_o | output | N_SLV | Strobe to each slave |
| s_we_o | output | 1 | Shared write enable |
| s_adr_o | output | AW | Shared word address |
| s_dat_o | output | DW | Shared write data |
| s_sel_o | output | SW | Shared byte selects |
| s_ack_i | input | N_SLV | Acknowledge from each slave |
| s_dat_i | input | N_SLV*DW | Read data from each slave |

## Verification
Arbitration and address decode resolve in the same cycle. A priority win can therefore land on an address that is unmapped, that falls in a disabled slave's region, or that lies in two overlapping regions. The bench sweeps every combination of requesting masters against eight addresses, rotated across the masters, so that the winner and the losers target every kind of region. It judges the slave-side lines and the per-master acknowledge and data against an arithmetic model of priority and match. Grant holding is covered by a separate sequence in which a higher-indexed master starts requesting while a lower one keeps its cycle line high.

// File: rtl/wbsb_pkg.sv
package wbsb_pkg;
  parameter int unsigned TAG_W = 8;  // address bits always compared

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wbsb_arb.sv
module wbsb_arb
  import wbsb_pkg::*;
#(
  parameter int unsigned N_MST = 4,
  parameter logic [N_MST-1:0] MST_EN = '1,
  localparam int unsigned MIW = idx_w(N_MST)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_MST-1:0] cyc_i,
  output logic             gnt_vld_o,
  output logic [MIW-1:0]   gnt_idx_o
);
  logic           vld_q;
  logic [MIW-1:0] idx_q;
  logic           hold;

  assign hold = vld_q && cyc_i[idx_q];

  always_comb begin
    gnt_vld_o = 1'b0;
    gnt_idx_o = '0;
    if (hold) begin
      gnt_vld_o = 1'b1;
      gnt_idx_o = idx_q;
    end else begin
      for (int i = 0; i < N_MST; i++) begin
        if (cyc_i[i] && MST_EN[i]) begin  // later index overrides
          gnt_vld_o = 1'b1;
          gnt_idx_o = MIW'(i);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= gnt_vld_o;
      idx_q <= gnt_idx_o;
    end
  end

  assert_grant_held_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_vld_o && cyc_i[gnt_idx_o]) |=>
      (!cyc_i[$past(gnt_idx_o)] || (gnt_vld_o && gnt_idx_o == $past(gnt_idx_o))));

  assert_grant_populated_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_vld_o |-> (MST_EN[gnt_idx_o] && cyc_i[gnt_idx_o]));
endmodule

// File: rtl/wbsb_dec.sv
module wbsb_dec
  import wbsb_pkg::*;
#(
  parameter int unsigned N_SLV = 16,
  parameter int unsigned AW = 30,
  localparam int unsigned MW = AW - TAG_W,
  localparam int unsigned SIW = idx_w(N_SLV),
  parameter logic [N_SLV-1:0] SLV_EN = '1,
  parameter logic [N_SLV*AW-1:0] SLV_BASE = '0,
  parameter logic [N_SLV*MW-1:0] SLV_MASK = '0
) (
  input  logic [AW-1:0]    adr_i,
  output logic             hit_o,
  output logic [SIW-1:0]   sel_idx_o,
  output logic [N_SLV-1:0] sel_oh_o
);
  logic [N_SLV-1:0] match;

  for (genvar j = 0; j < N_SLV; j++) begin : g_slv
    localparam logic [AW-1:0] BASE = SLV_BASE[j*AW +: AW];
    localparam logic [MW-1:0] MASK = SLV_MASK[j*MW +: MW];
    if (SLV_EN[j]) begin : g_on
      assign match[j] = (adr_i[AW-1 -: TAG_W] == BASE[AW-1 -: TAG_W]) &&
                        (((adr_i[MW-1:0] ^ BASE[MW-1:0]) & MASK) == '0);
    end else begin : g_off
      assign match[j] = 1'b0;
    end
  end

  always_comb begin
    hit_o     = |match;
    sel_idx_o = '0;
    for (int j = N_SLV - 1; j >= 0; j--) begin  // lowest index wins
      if (match[j]) sel_idx_o = SIW'(j);
    end
    sel_oh_o = hit_o ? (N_SLV'(1) << sel_idx_o) : '0;
  end

  always_comb begin
    if (hit_o && !$isunknown(adr_i)) begin
      assert_tag_match_R4: assert (adr_i[AW-1 -: TAG_W] ==
        SLV_BASE[sel_idx_o*AW + MW +: TAG_W]);
      assert_slave_populated_R6: assert (SLV_EN[sel_idx_o]);
    end
  end
endmodule

// File: rtl/wb_shared_bus.sv
module wb_shared_bus
  import wbsb_pkg::*;
#(
  parameter int unsigned N_MST = 4,
  parameter int unsigned N_SLV = 16,
  parameter int unsigned AW = 30,
  parameter int unsigned DW = 32,
  localparam int unsigned SW = DW / 8,
  localparam int unsigned MW = AW - TAG_W,
  localparam int unsigned MIW = idx_w(N_MST),
  localparam int unsigned SIW = idx_w(N_SLV),
  parameter logic [N_MST-1:0] MST_EN = '1,
  parameter logic [N_SLV-1:0] SLV_EN = '1,
  parameter logic [N_SLV*AW-1:0] SLV_BASE = '0,
  parameter logic [N_SLV*MW-1:0] SLV_MASK = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_MST-1:0]    m_cyc_i,
  input  logic [N_MST-1:0]    m_stb_i,
  input  logic [N_MST-1:0]    m_we_i,
  input  logic [N_MST*AW-1:0] m_adr_i,
  input  logic [N_MST*DW-1:0] m_dat_i,
  input  logic [N_MST*SW-1:0] m_sel_i,
  output logic [N_MST-1:0]    m_ack_o,
  output logic [N_MST*DW-1:0] m_dat_o,
  output logic [N_SLV-1:0]    s_cyc_o,
  output logic [N_SLV-1:0]    s_stb_o,
  output logic                s_we_o,
  output logic [AW-1:0]       s_adr_o,
  output logic [DW-1:0]       s_dat_o,
  output logic [SW-1:0]       s_sel_o,
  input  logic [N_SLV-1:0]    s_ack_i,
  input  logic [N_SLV*DW-1:0] s_dat_i
);
  logic             gnt_vld;
  logic [MIW-1:0]   gnt_idx;
  logic [AW-1:0]    gnt_adr;
  logic             hit;
  logic [SIW-1:0]   sidx;
  logic [N_SLV-1:0] soh;
  logic             act;

  wbsb_arb #(.N_MST(N_MST), .MST_EN(MST_EN)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(m_cyc_i),
    .gnt_vld_o(gnt_vld), .gnt_idx_o(gnt_idx)
  );

  assign gnt_adr = gnt_vld ? m_adr_i[gnt_idx*AW +: AW] : '0;

  wbsb_dec #(
    .N_SLV(N_SLV), .AW(AW), .SLV_EN(SLV_EN),
    .SLV_BASE(SLV_BASE), .SLV_MASK(SLV_MASK)
  ) u_dec (
    .adr_i(gnt_adr), .hit_o(hit), .sel_idx_o(sidx), .sel_oh_o(soh)
  );

  assign act     = gnt_vld && hit;  // no fallback on a miss
  assign s_cyc_o = act ? soh : '0;
  assign s_stb_o = (act && m_stb_i[gnt_idx]) ? soh : '0;
  assign s_adr_o = act ? gnt_adr : '0;
  assign s_we_o  = act && m_we_i[gnt_idx];
  assign s_dat_o = act ? m_dat_i[gnt_idx*DW +: DW] : '0;
  assign s_sel_o = act ? m_sel_i[gnt_idx*SW +: SW] : '0;

  for (genvar i = 0; i < N_MST; i++) begin : g_mst
    logic own;
    assign own = act && (gnt_idx == MIW'(i));
    assign m_ack_o[i] = own && s_ack_i[sidx];
    assign m_dat_o[i*DW +: DW] = own ? s_dat_i[sidx*DW +: DW] : '0;

    assert_ack_needs_cycle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_ack_o[i] |-> m_cyc_i[i]);
  end

  assert_one_slave_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_cyc_o) && ((s_stb_o & ~s_cyc_o) == '0));

  assert_one_master_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_ack_o));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((m_cyc_i & MST_EN) == '0) |-> (s_cyc_o == '0 && s_adr_o == '0 && m_ack_o == '0));
endmodule

// File: tb/wb_shared_bus_bench.sv
module wb_shared_bus_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int NS = 16;
  localparam logic [NM-1:0] MEN = 4'b1101;
  localparam logic [NS-1:0] SEN = 16'b1100_0000_0010_0111;

  function automatic logic [NS*30-1:0] mk_base();
    logic [NS*30-1:0] b;
    for (int j = 0; j < NS; j++) b[j*30 +: 30] = {8'(8'h20 + j), 22'h0};
    b[5*30 +: 30]  = 30'h0;
    b[14*30 +: 30] = {8'h2F, 22'h048000};
    b[15*30 +: 30] = {8'h2F, 22'h000000};
    return b;
  endfunction

  function automatic logic [NS*22-1:0] mk_mask();
    logic [NS*22-1:0] m = '0;
    m[5*22 +: 22]  = 22'h3FFFFF;
    m[14*22 +: 22] = 22'h3FC000;
    return m;
  endfunction

  localparam logic [NS*30-1:0] BASE = mk_base();
  localparam logic [NS*22-1:0] MASK = mk_mask();

  logic clk = 0, rst_n = 0;
  logic [NM-1:0] m_cyc = '0, m_stb = '0, m_we = '0;
  logic [NM*30-1:0] m_adr = '0;
  logic [NM*32-1:0] m_dat = '0;
  logic [NM*4-1:0] m_sel = '0;
  logic [NM-1:0] m_ack;
  logic [NM*32-1:0] m_rd;
  logic [NS-1:0] s_cyc, s_stb, s_ack;
  logic s_we;
  logic [29:0] s_adr;
  logic [31:0] s_wd;
  logic [3:0] s_sel;
  logic [NS*32-1:0] s_rd;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wb_shared_bus #(
    .N_MST(NM), .N_SLV(NS), .AW(30), .DW(32),
    .MST_EN(MEN), .SLV_EN(SEN), .SLV_BASE(BASE), .SLV_MASK(MASK)
  ) u_wb_shared_bus (
    .clk_i(clk), .rst_ni(rst_n),
    .m_cyc_i(m_cyc), .m_stb_i(m_stb), .m_we_i(m_we), .m_adr_i(m_adr),
    .m_dat_i(m_dat), .m_sel_i(m_sel), .m_ack_o(m_ack), .m_dat_o(m_rd),
    .s_cyc_o(s_cyc), .s_stb_o(s_stb), .s_we_o(s_we), .s_adr_o(s_adr),
    .s_dat_o(s_wd), .s_sel_o(s_sel), .s_ack_i(s_ack), .s_dat_i(s_rd)
  );

  for (genvar j = 0; j < NS; j++) begin : g_sl
    assign s_ack[j] = s_cyc[j] & s_stb[j];
    assign s_rd[j*32 +: 32] = 32'hC000_0000 | j;
  end

  function automatic logic [29:0] adr_of(input int k);
    case (k)
      0: return {8'h21, 22'h001234};  // slave 1
      1: return {8'h22, 22'h000000};  // slave 2
      2: return 30'h0;                 // slave 5, only word 0
      3: return 30'h1;                 // unmapped
      4: return {8'h23, 22'h000010};  // disabled slave 3
      5: return {8'h2F, 22'h048123};  // 14 and 15 overlap
      6: return {8'h2F, 22'h100000};  // slave 15 only
      default: return {8'h20, 22'h3FFFFF};  // slave 0
    endcase
  endfunction

  function automatic int exp_slave(input logic [29:0] a);
    for (int j = 0; j < NS; j++) begin
      logic [29:0] b = BASE[j*30 +: 30];
      if (SEN[j] && a[29:22] == b[29:22] &&
          ((a[21:0] ^ b[21:0]) & MASK[j*22 +: 22]) == 22'h0) return j;
    end
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_master(input int i, input logic [29:0] a, input int k);
    m_adr[i*30 +: 30] = a;
    m_dat[i*32 +: 32] = 32'hD000_0000 | (i << 8) | k;
    m_we[i]  = i[0];
    m_sel[i*4 +: 4] = 4'(1 << i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 idle slave side", {s_cyc, s_stb, s_we, s_adr, s_wd, s_sel}, '0);
    chk("R10 idle master side", {m_ack, m_rd}, '0);

    // R1 then R2: m0 holds against m3, then m3 takes over
    set_master(0, adr_of(0), 0);
    set_master(3, adr_of(7), 0);
    m_cyc = 4'b0001; m_stb = m_cyc;
    @(negedge clk);
    chk("R1 lone m0 granted", 128'(m_ack), 128'(4'b0001));
    m_cyc = 4'b1001; m_stb = m_cyc;
    @(negedge clk);
    chk("R2 m0 keeps grant ack", 128'(m_ack), 128'(4'b0001));
    chk("R2 m0 keeps grant addr", 128'(s_adr), 128'(adr_of(0)));
    @(negedge clk);
    chk("R2 m0 still held", 128'(s_cyc), 128'(16'h0002));
    m_cyc = 4'b1000; m_stb = m_cyc;
    @(negedge clk);
    chk("R2 m3 after release", 128'(m_ack), 128'(4'b1000));
    chk("R2 m3 slave 0", 128'(s_cyc), 128'(16'h0001));

    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < 8; k++) begin
        int w, s, nreq;
        logic [NS-1:0] e_cyc;
        logic [NM-1:0] e_ack;
        logic [127:0] e_rd, e_bus;
        string t;
        m_cyc = '0; m_stb = '0;
        @(negedge clk);
        for (int i = 0; i < NM; i++) set_master(i, adr_of((k + i) % 8), k);
        m_cyc = 4'(p); m_stb = 4'(p);
        @(negedge clk);
        w = -1; nreq = 0;
        for (int i = 0; i < NM; i++) if (p[i] && MEN[i]) begin w = i; nreq++; end
        s = (w >= 0) ? exp_slave(adr_of((k + w) % 8)) : -1;
        e_cyc = '0; e_ack = '0; e_rd = '0; e_bus = '0;
        if (s >= 0) begin
          e_cyc[s] = 1'b1;
          e_ack[w] = 1'b1;
          e_rd[w*32 +: 32] = 32'hC000_0000 | s;
          e_bus = {1'b1 & w[0], adr_of((k + w) % 8), 32'hD000_0000 | (w << 8) | k,
                   4'(1 << w)};
        end
        t = (w < 0) ? "R10" : ((k + w) % 8 == 3) ? "R7" : ((k + w) % 8 == 4) ? "R6" :
            ((k + w) % 8 == 5) ? "R5" : "R4";
        chk({t, " slave cycle lines"}, 128'(s_cyc), 128'(e_cyc));
        chk("R8 shared bus lines", 128'({s_we, s_adr, s_wd, s_sel}), e_bus);
        t = (w < 0) ? (p[1] ? "R3" : "R10") : (nreq > 1) ? "R1" : "R9";
        chk({t, " master acks"}, 128'(m_ack), 128'(e_ack));
        chk("R9 master read data", m_rd, e_rd);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule